// File: doc/BRIEF.md
# Multi-Context Transmit Command Scheduler

This block sits on the transmit side of a network interface that presents several virtual interfaces to software. Each context owns a private command slot and a private status word, so processors can post transmit fragments to their own context at the same time without sharing a lock. A fragment command carries an opaque buffer address, a byte length and a flag that says more fragments of the same packet follow.

Contexts that start a packet join an arrival-ordered queue. The scheduler serves the context at the head of the queue, turning each of its fragments into a DMA read request that lands at a running offset inside one shared packet buffer. While a packet is incomplete the head context keeps the scheduler, even when other contexts are waiting; only after its final fragment does the queue advance. A fragment that would run past the end of the shared buffer causes the whole packet to be thrown away and flagged.

Top module: `txsched`

## Requirements
- R1: Each context keeps its own command slot and status; a write selects its context by `cmdCtx` and a status read selects it by `statusCtx`, and one context's traffic never changes another context's status fields.
- R2: Contexts are served in the order in which they posted the first fragment of their packet.
- R3: While the head context has sent some but not all fragments of its packet, no DMA request is raised for any other context, even if others hold queued commands.
- R4: When the final fragment (more flag 0) of a packet is consumed, the context's complete bit becomes 1, its busy bit becomes 0, and the next queued context is served in the following cycle.
- R5: A DMA request shows the context, the command's address and length unchanged, the byte offset of that fragment inside the packet (0 for the first fragment, then the sum of earlier lengths) and a last flag equal to the inverse of the more flag; while `dmaReady` is 0 all these fields hold steady.
- R6: A command write to a context whose previous command has not yet been consumed is dropped, the pending command stays as it was, and the context's error bit becomes 1.
- R7: If offset plus length of a fragment exceeds the buffer size (parameter, 2048 bytes by default), that fragment and all remaining fragments of the packet produce no DMA request; the context ends with error 1, complete 0, busy 0 and byte count 0.
- R8: The status byte count is the sum of lengths of fragments issued for the current packet; the first accepted fragment of a new packet clears the byte count, the complete bit and the error bit.
- R9: After reset no DMA request is raised and every context reads busy 0, complete 0, error 0, byte count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrite | input | 1 | Command write strobe |
| cmdCtx | input | 2 | Context index of the write |
| cmdAddr | input | 32 | Opaque fragment buffer address |
| cmdLen | input | 16 | Fragment length in bytes |
| cmdMore | input | 1 | More fragments of this packet follow |
| dmaValid | output | 1 | DMA read request valid |
| dmaReady | input | 1 | DMA engine accepts the request |
| dmaCtx | output | 2 | Context of the request |
| dmaAddr | output | 32 | Source address of the request |
| dmaLen | output | 16 | Byte length of the request |
| dmaOffset | output | 12 | Destination offset in the shared packet buffer |
| dmaLast | output | 1 | Request carries the final fragment |
| statusCtx | input | 2 | Context whose status is shown |
| statusBusy | output | 1 | Context has a packet queued or in progress |
| statusComplete | output | 1 | Last packet finished normally |
| statusError | output | 1 | Rejected write or discarded packet |
| statusBytes | output | 12 | Bytes issued for the current packet |

## Verification
The bench builds the scheduler with four contexts and a 64-byte shared buffer in place of 2048. The small buffer lets a sweep of two-fragment packets in 8-byte steps cover every position of the overflow boundary: first fragment too long, second fragment pushing past the end, and sums landing exactly on 64. Four contexts keep ordering, locking and rejection cases short enough to check each request field directly.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
  typedef struct packed {
    logic capture;
    logic newPkt;
    logic issue;
    logic drop;
    logic endPkt;
  } txsched_strobe_t;
endpackage

// File: rtl/txsched_ctrl.sv
module txsched_ctrl
  import txsched_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic [CTX_W-1:0] cmdCtx,
  input  logic             dmaReady,
  input  logic             headMore,
  input  logic             headOver,
  input  logic [CTX_W-1:0] statusCtx,
  output logic             dmaValid,
  output logic [CTX_W-1:0] headCtx,
  output txsched_strobe_t  strb,
  output logic             statusBusy,
  output logic             statusComplete,
  output logic             statusError
);
  localparam int CNT_W = CTX_W + 1;

  logic [NUM_CTX-1:0] pendV, inQ, discard, cmpl, errF;
  logic [CTX_W-1:0]   order [NUM_CTX];
  logic [CTX_W-1:0]   rdPtr, wrPtr;
  logic [CNT_W-1:0]   count;
  logic               accept, reject, headReady;

  function automatic logic [CTX_W-1:0] nextPtr(input logic [CTX_W-1:0] p);
    return (p == CTX_W'(NUM_CTX - 1)) ? '0 : p + CTX_W'(1);
  endfunction

  always_comb begin
    accept      = cmdWrite && !pendV[cmdCtx];
    reject      = cmdWrite && pendV[cmdCtx];
    headCtx     = order[rdPtr];
    headReady   = (count != '0) && pendV[headCtx];
    dmaValid    = headReady && !discard[headCtx] && !headOver;
    strb.capture = accept;
    strb.newPkt  = accept && !inQ[cmdCtx];
    strb.issue   = dmaValid && dmaReady;
    strb.drop    = headReady && (discard[headCtx] || headOver);
    strb.endPkt  = (strb.issue || strb.drop) && !headMore;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendV   <= '0;
      inQ     <= '0;
      discard <= '0;
      cmpl    <= '0;
      errF    <= '0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      count   <= '0;
      for (int i = 0; i < NUM_CTX; i++) order[i] <= '0;
    end else begin
      if (strb.issue || strb.drop) pendV[headCtx] <= 1'b0;
      if (accept) pendV[cmdCtx] <= 1'b1;
      if (strb.newPkt) begin
        inQ[cmdCtx]  <= 1'b1;
        cmpl[cmdCtx] <= 1'b0;
        errF[cmdCtx] <= 1'b0;
        order[wrPtr] <= cmdCtx;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (reject) errF[cmdCtx] <= 1'b1;
      if (strb.drop) begin
        errF[headCtx]    <= 1'b1;
        discard[headCtx] <= headMore;
      end
      if (strb.issue && !headMore) cmpl[headCtx] <= 1'b1;
      if (strb.endPkt) begin
        inQ[headCtx] <= 1'b0;
        rdPtr        <= nextPtr(rdPtr);
      end
      case ({strb.newPkt, strb.endPkt})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign statusBusy     = inQ[statusCtx];
  assign statusComplete = cmpl[statusCtx];
  assign statusError    = errF[statusCtx];
endmodule

// File: rtl/txsched_dp.sv
module txsched_dp
  import txsched_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int CTX_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  parameter int OFF_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  txsched_strobe_t   strb,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdMore,
  input  logic [CTX_W-1:0]  headCtx,
  input  logic [CTX_W-1:0]  statusCtx,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [OFF_W-1:0]  dmaOffset,
  output logic              headMore,
  output logic              headOver,
  output logic [OFF_W-1:0]  statusBytes
);
  localparam int SUM_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

  logic [ADDR_W-1:0] addrR  [NUM_CTX];
  logic [LEN_W-1:0]  lenR   [NUM_CTX];
  logic [OFF_W-1:0]  bytesR [NUM_CTX];
  logic [NUM_CTX-1:0] moreR;
  logic [OFF_W-1:0]  offset;
  logic [SUM_W-1:0]  reach;

  always_comb begin
    reach    = SUM_W'(offset) + SUM_W'(lenR[headCtx]);
    headOver = reach > SUM_W'(BUF_BYTES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moreR  <= '0;
      offset <= '0;
      for (int i = 0; i < NUM_CTX; i++) begin
        addrR[i]  <= '0;
        lenR[i]   <= '0;
        bytesR[i] <= '0;
      end
    end else begin
      if (strb.capture) begin
        addrR[cmdCtx] <= cmdAddr;
        lenR[cmdCtx]  <= cmdLen;
        moreR[cmdCtx] <= cmdMore;
      end
      if (strb.newPkt) bytesR[cmdCtx] <= '0;
      if (strb.issue) bytesR[headCtx] <= bytesR[headCtx] + OFF_W'(lenR[headCtx]);
      if (strb.drop) bytesR[headCtx] <= '0;
      if (strb.endPkt) offset <= '0;
      else if (strb.issue) offset <= offset + OFF_W'(lenR[headCtx]);
    end
  end

  assign dmaAddr     = addrR[headCtx];
  assign dmaLen      = lenR[headCtx];
  assign dmaOffset   = offset;
  assign headMore    = moreR[headCtx];
  assign statusBytes = bytesR[statusCtx];
endmodule

// File: rtl/txsched.sv
module txsched
  import txsched_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  localparam int CTX_W    = $clog2(NUM_CTX),
  localparam int OFF_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [CTX_W-1:0]  cmdCtx,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdMore,
  output logic              dmaValid,
  input  logic              dmaReady,
  output logic [CTX_W-1:0]  dmaCtx,
  output logic [ADDR_W-1:0] dmaAddr,
  output logic [LEN_W-1:0]  dmaLen,
  output logic [OFF_W-1:0]  dmaOffset,
  output logic              dmaLast,
  input  logic [CTX_W-1:0]  statusCtx,
  output logic              statusBusy,
  output logic              statusComplete,
  output logic              statusError,
  output logic [OFF_W-1:0]  statusBytes
);
  txsched_strobe_t  strb;
  logic [CTX_W-1:0] headCtx;
  logic             headMore, headOver;

  txsched_ctrl #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdCtx(cmdCtx),
    .dmaReady(dmaReady), .headMore(headMore), .headOver(headOver),
    .statusCtx(statusCtx), .dmaValid(dmaValid), .headCtx(headCtx),
    .strb(strb), .statusBusy(statusBusy), .statusComplete(statusComplete),
    .statusError(statusError)
  );

  txsched_dp #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
               .BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdCtx(cmdCtx), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdMore(cmdMore), .headCtx(headCtx), .statusCtx(statusCtx),
    .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaOffset(dmaOffset),
    .headMore(headMore), .headOver(headOver), .statusBytes(statusBytes)
  );

  assign dmaCtx  = headCtx;
  assign dmaLast = !headMore;
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
  parameter int CTX_W     = 2,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  parameter int OFF_W     = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaValid,
  input logic              dmaReady,
  input logic [CTX_W-1:0]  dmaCtx,
  input logic [ADDR_W-1:0] dmaAddr,
  input logic [LEN_W-1:0]  dmaLen,
  input logic [OFF_W-1:0]  dmaOffset,
  input logic              dmaLast,
  input logic [CTX_W-1:0]  statusCtx,
  input logic              statusBusy,
  input logic              statusComplete
);
  localparam int SUM_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid && !dmaReady |=> dmaValid && $stable(dmaCtx) && $stable(dmaAddr)
      && $stable(dmaLen) && $stable(dmaOffset) && $stable(dmaLast));

  a_r7_in_buffer: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> (SUM_W'(dmaOffset) + SUM_W'(dmaLen)) <= SUM_W'(BUF_BYTES));

  a_r3_stay_on_ctx: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid && dmaReady && !dmaLast |=> !dmaValid || dmaCtx == $past(dmaCtx));

  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusComplete) && $stable(statusCtx) |-> !statusBusy);
endmodule

bind txsched txsched_chk #(.CTX_W(CTX_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                           .BUF_BYTES(BUF_BYTES), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .dmaValid(dmaValid), .dmaReady(dmaReady),
  .dmaCtx(dmaCtx), .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaOffset(dmaOffset),
  .dmaLast(dmaLast), .statusCtx(statusCtx), .statusBusy(statusBusy),
  .statusComplete(statusComplete)
);

// File: tb/test_txsched.sv
module test_txsched;
  localparam int NUM_CTX   = 4;
  localparam int CTX_W     = 2;
  localparam int ADDR_W    = 32;
  localparam int LEN_W     = 16;
  localparam int BUF_BYTES = 64;
  localparam int OFF_W     = $clog2(BUF_BYTES + 1);

  logic              clk = 1'b0;
  logic              rstN;
  logic              cmdWrite;
  logic [CTX_W-1:0]  cmdCtx;
  logic [ADDR_W-1:0] cmdAddr;
  logic [LEN_W-1:0]  cmdLen;
  logic              cmdMore;
  logic              dmaValid, dmaReady, dmaLast;
  logic [CTX_W-1:0]  dmaCtx;
  logic [ADDR_W-1:0] dmaAddr;
  logic [LEN_W-1:0]  dmaLen;
  logic [OFF_W-1:0]  dmaOffset;
  logic [CTX_W-1:0]  statusCtx;
  logic              statusBusy, statusComplete, statusError;
  logic [OFF_W-1:0]  statusBytes;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  txsched #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) i_txsched (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdCtx(cmdCtx), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdMore(cmdMore), .dmaValid(dmaValid), .dmaReady(dmaReady),
    .dmaCtx(dmaCtx), .dmaAddr(dmaAddr), .dmaLen(dmaLen), .dmaOffset(dmaOffset),
    .dmaLast(dmaLast), .statusCtx(statusCtx), .statusBusy(statusBusy),
    .statusComplete(statusComplete), .statusError(statusError), .statusBytes(statusBytes)
  );

  task automatic checkEq(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic post(int c, logic [31:0] a, int l, bit m);
    cmdWrite = 1'b1;
    cmdCtx   = CTX_W'(c);
    cmdAddr  = a;
    cmdLen   = LEN_W'(l);
    cmdMore  = m;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic expDma(string req, int c, logic [31:0] a, int l, int off, bit last);
    checkEq(req, "dmaValid", dmaValid, 1);
    checkEq(req, "dmaCtx", dmaCtx, c);
    checkEq(req, "dmaAddr", dmaAddr, a);
    checkEq(req, "dmaLen", dmaLen, l);
    checkEq(req, "dmaOffset", dmaOffset, off);
    checkEq(req, "dmaLast", dmaLast, last);
  endtask

  task automatic expIdle(string req);
    checkEq(req, "dmaValid idle", dmaValid, 0);
  endtask

  task automatic expStat(string req, int c, bit busy, bit done, bit err, int bytes);
    statusCtx = CTX_W'(c);
    #1;
    checkEq(req, "statusBusy", statusBusy, busy);
    checkEq(req, "statusComplete", statusComplete, done);
    checkEq(req, "statusError", statusError, err);
    checkEq(req, "statusBytes", statusBytes, bytes);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmdWrite = 1'b0; cmdCtx = '0; cmdAddr = '0; cmdLen = '0;
    cmdMore = 1'b0; dmaReady = 1'b0; statusCtx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    expIdle("R9");
    for (int c = 0; c < NUM_CTX; c++) expStat("R9", c, 0, 0, 0, 0);
    step();

    // R2 / R1: arrival order, per-context slots
    post(3, 32'hA300_0003, 3, 0);
    post(0, 32'hA000_0000, 7, 0);
    post(1, 32'hA100_0001, 9, 0);
    expStat("R1", 0, 1, 0, 0, 0);
    expStat("R1", 2, 0, 0, 0, 0);
    dmaReady = 1'b1;
    expDma("R2", 3, 32'hA300_0003, 3, 0, 1);
    step();
    expDma("R2", 0, 32'hA000_0000, 7, 0, 1);
    step();
    expDma("R2", 1, 32'hA100_0001, 9, 0, 1);
    step();
    expIdle("R4");
    expStat("R4", 3, 0, 1, 0, 3);
    expStat("R1", 0, 0, 1, 0, 7);
    expStat("R1", 1, 0, 1, 0, 9);

    // R5: request held while not accepted
    dmaReady = 1'b0;
    post(2, 32'h0000_BEEF, 4, 0);
    step();
    step();
    expDma("R5", 2, 32'h0000_BEEF, 4, 0, 1);
    dmaReady = 1'b1;
    step();
    expIdle("R5");

    // R6: rejected write to a context with a pending command
    dmaReady = 1'b0;
    post(0, 32'h1111_0000, 5, 0);
    post(0, 32'h2222_0000, 6, 0);
    expDma("R6", 0, 32'h1111_0000, 5, 0, 1);
    expStat("R6", 0, 1, 0, 1, 0);
    dmaReady = 1'b1;
    step();
    expStat("R6", 0, 0, 1, 1, 5);

    // R3: lock on partially sent packet
    dmaReady = 1'b0;
    post(1, 32'h0000_1000, 10, 1);
    post(2, 32'h0000_2000, 5, 0);
    dmaReady = 1'b1;
    expDma("R3", 1, 32'h0000_1000, 10, 0, 0);
    step();
    expIdle("R3");
    step();
    expIdle("R3");
    expStat("R3", 1, 1, 0, 0, 10);
    expStat("R3", 2, 1, 0, 0, 0);
    post(1, 32'h0000_1100, 6, 0);
    expDma("R5", 1, 32'h0000_1100, 6, 10, 1);
    step();
    expDma("R4", 2, 32'h0000_2000, 5, 0, 1);
    step();
    expStat("R8", 1, 0, 1, 0, 16);
    expStat("R8", 2, 0, 1, 0, 5);

    // R7 / R8: overflow sweep over two-fragment packets
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 10; j++) begin
        int a = 8 * i;
        int b = 8 * j;
        int c = (i + j) % NUM_CTX;
        bit aOver = a > BUF_BYTES;
        bit bOver = !aOver && (a + b > BUF_BYTES);
        logic [31:0] addrA = 32'h4000_0000 + 32'(i * 256 + j);
        logic [31:0] addrB = 32'h5000_0000 + 32'(i * 256 + j);
        post(c, addrA, a, 1);
        if (aOver) expIdle("R7");
        else expDma("R7", c, addrA, a, 0, 0);
        step();
        post(c, addrB, b, 0);
        if (aOver || bOver) expIdle("R7");
        else expDma("R8", c, addrB, b, a, 1);
        step();
        if (aOver || bOver) expStat("R7", c, 0, 0, 1, 0);
        else expStat("R8", c, 0, 1, 0, a + b);
        expIdle("R7");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule